// File: doc/BRIEF.md
# Four-Way Word-Interleaved Refill Memory

This block fills cache lines from a store split into independent banks. Adjacent word addresses fall into adjacent banks. A line read sends a single row address to every bank in one cycle. The banks then run their slow accesses at the same time, and the controller streams the fetched words back to the cache, one word per cycle, lowest address first. A four-word line therefore costs one address cycle, one bank access and four transfer cycles (1 + 6 + 4 = 11). Fetching the words one after another through a single bank would cost 4 × (1 + 6 + 1) = 32 cycles.

Single-word writes tie up only the bank they address. A write to a different bank can follow two cycles later. A second write to the same bank waits until that bank's access has finished. A line read starts only when every bank is idle. Each bank is modelled as an internal array with a fixed access latency.

Top module: `ilv_mem_ctl`

## Requirements
- R1: The bank is selected by word address bits [1:0] (bank = address mod 4). The row inside the bank is taken from the remaining upper bits.
- R2: Take a line read accepted at clock edge k. rd_valid is high in the four cycles that follow edges k+7, k+8, k+9 and k+10, and low in every other cycle from k to k+11.
- R3: A line refill occupies exactly 11 cycles, counted from the accept edge through the cycle of its last word. This is fewer than the 32 cycles of a refill without interleaving.
- R4: A read returns the words of the aligned line in ascending address order, starting at the address with bits [1:0] cleared. Bits [1:0] of a read address are ignored. rd_last is high together with the fourth word only.
- R5: req_ready stays low from the accept edge of a read until its last word has been sent. It is high again in the cycle after the last word.
- R6: A write accepted at edge k lets a write to another bank be accepted at edge k+2. A write to the same bank, or a line read, can be accepted no earlier than edge k+8.
- R7: While reset is held, and directly after it, req_ready is high and rd_valid and rd_last are low.
- R8: A line read returns the data most recently written to each of its four addresses.
- R9: Writes never raise rd_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = single-word write, 0 = line read |
| req_addr | input | ADDR_W (8) | Word address |
| req_wdata | input | DATA_W (32) | Write data |
| req_ready | output | 1 | Request is taken at the clock edge when both valid and ready are high |
| rd_valid | output | 1 | rd_data holds a word of the line |
| rd_data | output | DATA_W (32) | Returned word |
| rd_last | output | 1 | Fourth and final word of the line |

## Verification
Line reads are issued at aligned addresses, at unaligned addresses and at the top of the address space. A wrong base, a wrong word order or a missing low-bit mask each show up as a data mismatch. Write bursts mix bank-changing and bank-repeating addresses, so the accept spacing of 2 versus 8 edges reveals whether bank selection and per-bank busy tracking follow the low address bits. A read issued right after the writes tests both the wait for all banks to be idle and the return of freshly written data. The cycle of each returned word is compared against the 11-cycle budget, so any added or missing pipeline stage is detected.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_WAIT = 2'd2,
      ST_XFER = 2'd3
   } ilv_state_t;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
   parameter int DATA_W = 32,
   parameter int ROW_W  = 6,
   parameter int LAT    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              we,
   input  logic [ROW_W-1:0]  row,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              busy,
   output logic              finishing
);
   localparam int DEPTH = 1 << ROW_W;
   localparam int CNT_W = $clog2(LAT + 1);

   if (LAT < 1) begin : g_bad_lat
      $error("ilv_bank: LAT must be at least 1");
   end

   logic [DATA_W-1:0] cells [DEPTH];
   logic [CNT_W-1:0]  remain;

   always_ff @(posedge clk) begin
      if (start && we)  cells[row] <= wdata;
      if (start && !we) rdata      <= cells[row];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      remain <= '0;
      else if (start)  remain <= CNT_W'(LAT);
      else if (busy)   remain <= remain - 1'b1;
   end

   assign busy      = (remain != '0);
   assign finishing = (remain == CNT_W'(1));
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
   import ilv_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   input  logic [NUM_BANKS-1:0]        bank_busy,
   input  logic                        all_finishing,
   output logic                        req_ready,
   output logic [NUM_BANKS-1:0]        bank_start,
   output logic                        bank_we,
   output logic [ADDR_W-$clog2(NUM_BANKS)-1:0] row,
   output logic [DATA_W-1:0]           wdata,
   output logic [$clog2(NUM_BANKS)-1:0] word_idx,
   output logic                        rd_valid,
   output logic                        rd_last
);
   localparam int BS_W  = $clog2(NUM_BANKS);

   ilv_state_t          state;
   logic [ADDR_W-1:0]   addr_q;
   logic                write_q;
   logic [BS_W-1:0]     idx_q;
   logic                accept;
   logic [BS_W-1:0]     req_bank;

   assign req_bank  = req_addr[BS_W-1:0];
   assign req_ready = (state == ST_IDLE) &&
                      (req_write ? !bank_busy[req_bank] : (bank_busy == '0));
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         addr_q  <= '0;
         write_q <= 1'b0;
         wdata   <= '0;
         idx_q   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) begin
               state   <= ST_ADDR;
               addr_q  <= req_addr;
               write_q <= req_write;
               wdata   <= req_wdata;
            end
            ST_ADDR: state <= write_q ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (all_finishing) begin
               state <= ST_XFER;
               idx_q <= '0;
            end
            ST_XFER: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == BS_W'(NUM_BANKS - 1)) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      bank_start = '0;
      if (state == ST_ADDR) begin
         if (write_q) bank_start[addr_q[BS_W-1:0]] = 1'b1;
         else         bank_start = '1;
      end
   end

   assign bank_we  = write_q;
   assign row      = addr_q[ADDR_W-1:BS_W];
   assign word_idx = idx_q;
   assign rd_valid = (state == ST_XFER);
   assign rd_last  = (state == ST_XFER) && (idx_q == BS_W'(NUM_BANKS - 1));
endmodule

// File: rtl/ilv_mem_ctl.sv
module ilv_mem_ctl #(
   parameter int NUM_BANKS  = 4,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int ACCESS_LAT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last
);
   localparam int BS_W  = $clog2(NUM_BANKS);
   localparam int ROW_W = ADDR_W - BS_W;

   if (NUM_BANKS < 2 || (1 << BS_W) != NUM_BANKS) begin : g_bad_banks
      $error("ilv_mem_ctl: NUM_BANKS must be a power of two >= 2");
   end
   if (ROW_W < 1) begin : g_bad_addr
      $error("ilv_mem_ctl: ADDR_W too small for NUM_BANKS");
   end
   if (ACCESS_LAT < 1) begin : g_bad_lat
      $error("ilv_mem_ctl: ACCESS_LAT must be at least 1");
   end

   logic [NUM_BANKS-1:0]             bank_start;
   logic [NUM_BANKS-1:0]             bank_busy;
   logic [NUM_BANKS-1:0]             bank_fin;
   logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
   logic                             bank_we;
   logic [ROW_W-1:0]                 row;
   logic [DATA_W-1:0]                wdata;
   logic [BS_W-1:0]                  word_idx;

   ilv_seq #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_addr      (req_addr),
      .req_wdata     (req_wdata),
      .bank_busy     (bank_busy),
      .all_finishing (&bank_fin),
      .req_ready     (req_ready),
      .bank_start    (bank_start),
      .bank_we       (bank_we),
      .row           (row),
      .wdata         (wdata),
      .word_idx      (word_idx),
      .rd_valid      (rd_valid),
      .rd_last       (rd_last)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ilv_bank #(
         .DATA_W (DATA_W),
         .ROW_W  (ROW_W),
         .LAT    (ACCESS_LAT)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .start     (bank_start[b]),
         .we        (bank_we),
         .row       (row),
         .wdata     (wdata),
         .rdata     (bank_rdata[b]),
         .busy      (bank_busy[b]),
         .finishing (bank_fin[b])
      );
   end

   assign rd_data = rd_valid ? bank_rdata[word_idx] : '0;
endmodule

// File: rtl/ilv_mem_ctl_chk.sv
module ilv_mem_ctl_chk #(
   parameter int NUM_BANKS  = 4,
   parameter int ACCESS_LAT = 6
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_write,
   input logic req_ready,
   input logic rd_valid,
   input logic rd_last
);
   localparam int TOT = 1 + ACCESS_LAT + NUM_BANKS;

   logic [15:0] since_rd;
   logic        rd_acc;

   assign rd_acc = req_valid && req_ready && !req_write;

   always_ff @(posedge clk) begin
      if (!rst_n)              since_rd <= '0;
      else if (rd_acc)         since_rd <= 16'd1;
      else if (since_rd != '0) since_rd <= since_rd + 16'd1;
   end

   // R3: the last word arrives in the 11th cycle of the refill
   a_r3_refill_len: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> since_rd == 16'(TOT));

   a_r4_last_with_data: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);

   a_r5_busy_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !req_ready);

   a_r5_no_accept_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> !req_ready);

   a_r9_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write) |=> !rd_valid);

   a_r2_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_last) |=> rd_valid);
endmodule

bind ilv_mem_ctl ilv_mem_ctl_chk #(
   .NUM_BANKS  (NUM_BANKS),
   .ACCESS_LAT (ACCESS_LAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_ready (req_ready),
   .rd_valid  (rd_valid),
   .rd_last   (rd_last)
);

// File: tb/sim_ilv_mem_ctl.sv
`timescale 1ns/1ps
module sim_ilv_mem_ctl;
   localparam int NB  = 4;
   localparam int AW  = 8;
   localparam int DW  = 32;
   localparam int LAT = 6;
   localparam int EXP_ILV  = 1 + LAT + NB * 1;
   localparam int EXP_FLAT = NB * (1 + LAT + 1);

   // upper byte: request address, lower byte: expected aligned base
   localparam logic [15:0] VEC [6] = '{
      16'h0000, 16'h0504, 16'h0B08, 16'hFFFC, 16'h4240, 16'h1310
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rd_valid, rd_last;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   logic          wr_saw_valid = 1'b0;
   logic [DW-1:0] model [256];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ilv_mem_ctl #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW), .ACCESS_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
   );

   function automatic logic [DW-1:0] pat(int a);
      return 32'hC3A5_0000 ^ 32'(a * 32'h0001_0203);
   endfunction

   task automatic check(input logic ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] d, output int acc);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
      #0.1;
      while (!req_ready) begin
         if (rd_valid) wr_saw_valid = 1'b1;
         @(negedge clk);
      end
      if (rd_valid) wr_saw_valid = 1'b1;
      acc = cyc;
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0;
      model[a] = d;
   endtask

   task automatic do_read(input int a, input int base, output int acc);
      logic pat_ok = 1'b1, rdy_ok = 1'b1;
      int first_j = -1, last_j = -1;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
      #0.1;
      while (!req_ready) @(negedge clk);
      acc = cyc;
      @(posedge clk); #1;
      req_valid = 1'b0;
      for (int j = 0; j <= 11; j++) begin
         @(negedge clk);
         if (rd_valid !== (j >= 7 && j <= 10)) pat_ok = 1'b0;
         if (rd_last  !== (j == 10)) pat_ok = 1'b0;
         if (j <= 10 && req_ready !== 1'b0) rdy_ok = 1'b0;
         if (j == 11 && req_ready !== 1'b1) rdy_ok = 1'b0;
         if (rd_valid) begin
            if (first_j < 0) first_j = j;
            last_j = j;
         end
         if (j >= 7 && j <= 10)
            // R4 / R8: word order from aligned base, freshest data
            check(rd_data === model[base + j - 7], "R4", $sformatf("word %0d of 0x%0h", j - 7, a),
                  rd_data, model[base + j - 7]);
      end
      check(pat_ok, "R2", "valid/last timing", first_j, 7);
      // R3: refill length against the non-interleaved cost
      check((last_j + 1 == EXP_ILV) && (EXP_ILV < EXP_FLAT), "R3", "refill cycles",
            last_j + 1, EXP_ILV);
      check(rdy_ok, "R5", "ready low during refill", rdy_ok, 1);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<60000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int t0, t1, t2, t3, t4, t5;
      // R7: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(req_ready === 1'b1 && rd_valid === 1'b0 && rd_last === 1'b0, "R7",
            "outputs in reset", {req_ready, rd_valid, rd_last}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready === 1'b1 && rd_valid === 1'b0, "R7", "outputs after reset",
            {req_ready, rd_valid}, 2'b10);

      // fill the lines the vector table reads
      foreach (VEC[i])
         for (int w = 0; w < NB; w++)
            do_write(int'(VEC[i][7:0]) + w, pat(int'(VEC[i][7:0]) + w), t0);

      // vector table walk: R1, R2, R3, R4, R5
      foreach (VEC[i])
         do_read(int'(VEC[i][15:8]), int'(VEC[i][7:0]), t0);

      // R6 / R1: accept spacing by bank of the low address bits
      do_write(8'h25, 32'h1111_0025, t1);
      do_write(8'h26, 32'h2222_0026, t2);
      check(t2 - t1 == 2, "R6", "other bank write spacing", t2 - t1, 2);
      do_write(8'h2A, 32'h3333_002A, t3);
      check(t3 - t2 == 8, "R1", "same bank (addr mod 4) write spacing", t3 - t2, 8);
      do_write(8'h27, 32'h4444_0027, t4);
      check(t4 - t3 == 2, "R6", "bank 3 after bank 2", t4 - t3, 2);
      do_write(8'h24, 32'h5555_0024, t5);
      check(t5 - t4 == 2, "R6", "bank 0 after bank 3", t5 - t4, 2);
      // R6 / R8: read waits for all banks idle and sees new data
      do_read(8'h26, 8'h24, t0);
      check(t0 - t5 == 8, "R6", "read after write spacing", t0 - t5, 8);
      // R8: overwrite then reread
      do_write(8'h05, 32'hDEAD_BEEF, t1);
      do_read(8'h07, 8'h04, t0);
      // R9: writes never raised rd_valid
      check(!wr_saw_valid, "R9", "rd_valid during writes", wr_saw_valid, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule